// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Binary Counter

This block is a synchronous binary counter built from a chain of identical 8-bit stages. On every rising clock edge the whole chain either loads a parallel word, counts up by one, counts down by one, or keeps its value. A load request always wins over counting. A direction input picks between incrementing and decrementing.

Each stage has two active-low count enables. The first is the shared local enable. The second is the carry enable, which is fed from the stage below. Each stage drives an active-low terminal flag, computed combinationally. The flag is low only when the stage's carry enable is low and the stage sits at its end value: all ones when counting up, all zeros when counting down. Feeding each stage's flag into the carry enable of the next stage up makes the chain behave as one wide counter, with every bit changing on the same edge. The flag of the top stage leaves the block as the overall carry/borrow, so the block can in turn be cascaded further.

The stage count is a parameter. The parallel data and the count value are exposed as flat words of STAGES×8 bits, with stage 0 in the least significant byte. A synchronous active-high reset clears the count.

Top module: `updn_chain`

## Requirements
- R1: When `load_n` is 0 at a rising edge, `q` takes the value of `din` on that edge, whatever the values of `up`, `par_en_n` and `chain_en_n`.
- R2: When `load_n` is 1, `par_en_n` is 0, `chain_en_n` is 0 and `up` is 1 at a rising edge, `q` increases by one.
- R3: When `load_n` is 1, `par_en_n` is 0, `chain_en_n` is 0 and `up` is 0 at a rising edge, `q` decreases by one.
- R4: When `load_n` is 1 and either `par_en_n` or `chain_en_n` is 1 at a rising edge, `q` keeps its value.
- R5: Counting wraps modulo 2^(8·STAGES). Counting up from all ones gives zero, and counting down from zero gives all ones.
- R6: `carry_n` is 0 exactly when `chain_en_n` is 0 and `q` is at its end value for the current direction: all ones when `up`=1, all zeros when `up`=0. It follows `up` and `chain_en_n` with no clock edge in between.
- R7: `par_en_n` has no effect on `carry_n`. A held chain at its end value still reports it.
- R8: Internal stages carry and borrow through byte boundaries on the same edge, so the chain counts exactly like a single counter of 8·STAGES bits.
- R9: When `rst` is 1 at a rising edge, `q` becomes 0. Reset has priority over load and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears the count |
| load_n | input | 1 | Active-low parallel load request |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| par_en_n | input | 1 | Active-low count enable shared by all stages |
| chain_en_n | input | 1 | Active-low carry enable into the lowest stage |
| din | input | STAGES*8 | Parallel load word, stage 0 in bits 7:0 |
| q | output | STAGES*8 | Current count |
| carry_n | output | 1 | Active-low terminal flag of the top stage |

## Verification
Every cycle, the stage assertions check that a load, an increment, a decrement, a hold or a reset produces the right next byte. They also check that a stage whose carry enable is high never flags its end value. At the top, an assertion checks the all-ones-to-zero wrap. Two things only the bench scenarios can show. The first is that the stages together form one correct wide counter, which needs a full up sweep through every 16-bit value and a down run across zero and across a byte boundary. The second is that the load priority, the hold behaviour, the end-value flag that follows the direction and the flag that ignores `par_en_n` all behave as required.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

    localparam int unsigned STAGE_W = 8;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } op_e;

    typedef struct packed {
        logic load_n;
        logic up;
        logic par_en_n;
        logic chain_en_n;
    } ctrl_t;

    // Load wins; counting needs both active-low enables low.
    function automatic op_e pick_op(ctrl_t c);
        if (!c.load_n)
            return OP_LOAD;
        else if (!c.par_en_n && !c.chain_en_n)
            return c.up ? OP_INC : OP_DEC;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/updn_term_detect.sv
module updn_term_detect #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] value,
    input  logic         up,
    input  logic         chain_en_n,
    output logic         term_n
);
    logic at_top;
    logic at_bottom;
    logic at_end;

    always_comb begin
        at_top    = &value;
        at_bottom = ~|value;
        at_end    = up ? at_top : at_bottom;
        term_n    = ~(at_end & ~chain_en_n);
    end
endmodule

// File: rtl/updn_stage.sv
module updn_stage
    import updn_cnt_pkg::*;
#(
    parameter int unsigned W = STAGE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         term_n
);
    op_e          op;
    logic [W-1:0] q_nxt;

    always_comb begin
        op = pick_op(ctrl);
        unique case (op)
            OP_LOAD: q_nxt = din;
            OP_INC:  q_nxt = q + W'(1);
            OP_DEC:  q_nxt = q - W'(1);
            default: q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_nxt;
    end

    updn_term_detect #(.W(W)) u_term (
        .value      (q),
        .up         (ctrl.up),
        .chain_en_n (ctrl.chain_en_n),
        .term_n     (term_n)
    );

    // R1
    load_takes_din_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.load_n |=> q == $past(din));
    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.load_n && !ctrl.par_en_n && !ctrl.chain_en_n && ctrl.up)
        |=> q == W'($past(q) + W'(1)));
    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.load_n && !ctrl.par_en_n && !ctrl.chain_en_n && !ctrl.up)
        |=> q == W'($past(q) - W'(1)));
    // R4
    hold_value_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.load_n && (ctrl.par_en_n || ctrl.chain_en_n)) |=> $stable(q));
    // R6
    term_gated_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.chain_en_n |-> term_n);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> q == '0);
endmodule

// File: rtl/updn_chain.sv
module updn_chain
    import updn_cnt_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_n,
    input  logic                      up,
    input  logic                      par_en_n,
    input  logic                      chain_en_n,
    input  logic [STAGES*STAGE_W-1:0] din,
    output logic [STAGES*STAGE_W-1:0] q,
    output logic                      carry_n
);
    localparam int unsigned TOTAL_W = STAGES * STAGE_W;

    logic [STAGES:0] link_n;

    assign link_n[0] = chain_en_n;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        ctrl_t stage_ctrl;
        assign stage_ctrl = '{load_n: load_n, up: up,
                              par_en_n: par_en_n, chain_en_n: link_n[s]};

        updn_stage #(.W(STAGE_W)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .ctrl   (stage_ctrl),
            .din    (din[s*STAGE_W +: STAGE_W]),
            .q      (q[s*STAGE_W +: STAGE_W]),
            .term_n (link_n[s+1])
        );
    end

    assign carry_n = link_n[STAGES];

    // R5
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && !par_en_n && !chain_en_n && up && (q == {TOTAL_W{1'b1}}))
        |=> q == '0);
    // R7
    held_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (par_en_n && !chain_en_n && up && (q == {TOTAL_W{1'b1}})) |-> !carry_n);
endmodule

// File: tb/updn_chain_tb.sv
`timescale 1ns/1ps
module updn_chain_tb;
    localparam int unsigned STAGES = 2;
    localparam int unsigned TW = STAGES * 8;
    localparam logic [TW-1:0] ONES = {TW{1'b1}};

    logic          clk = 1'b0;
    logic          rst, load_n, up, par_en_n, chain_en_n;
    logic [TW-1:0] din, q;
    logic          carry_n;
    logic [TW-1:0] exp_q;
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    always #2.5 clk = ~clk;

    updn_chain #(.STAGES(STAGES)) u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .up(up),
        .par_en_n(par_en_n), .chain_en_n(chain_en_n),
        .din(din), .q(q), .carry_n(carry_n)
    );

    function automatic logic exp_carry();
        logic at_end;
        at_end = up ? (exp_q == ONES) : (exp_q == '0);
        return ~(at_end & ~chain_en_n);
    endfunction

    task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One edge: update the model from the inputs, then compare after the edge.
    task automatic tick(input string req);
        @(posedge clk);
        if (rst)                         exp_q = '0;
        else if (!load_n)                exp_q = din;
        else if (!par_en_n && !chain_en_n) exp_q = up ? exp_q + 1'b1 : exp_q - 1'b1;
        @(negedge clk);
        chk({req, " q"}, q, exp_q);
        chk({req, " carry_n"}, TW'(carry_n), TW'(exp_carry()));
    endtask

    task automatic flag_now(input string req);
        #0.5;
        chk({req, " carry_n"}, TW'(carry_n), TW'(exp_carry()));
    endtask

    initial begin
        rst = 1'b1; load_n = 1'b1; up = 1'b0; par_en_n = 1'b0; chain_en_n = 1'b0;
        din = '0; exp_q = '0;
        @(negedge clk);
        tick("R9 reset");
        tick("R9 reset");
        up = 1'b1;
        flag_now("R6 direction up at zero");
        up = 1'b0;
        flag_now("R6 direction down at zero");
        rst = 1'b0; up = 1'b1;

        // full up sweep across every value and the wrap (R2 R5 R8)
        for (int i = 0; i < (1 << TW) + 4; i++) tick("R2 R5 R8 up sweep");

        // load beats enables and direction (R1)
        load_n = 1'b0; din = ONES - 2; par_en_n = 1'b1; chain_en_n = 1'b1; up = 1'b0;
        tick("R1 load with enables off");
        din = 16'h1234; par_en_n = 1'b0; chain_en_n = 1'b0; up = 1'b1;
        tick("R1 load with counting enabled");
        din = ONES - 2;
        tick("R1 reload");
        load_n = 1'b1;
        for (int i = 0; i < 5; i++) tick("R5 up wrap");

        // hold via either enable (R4); flag ignores par_en_n (R7)
        par_en_n = 1'b1;
        for (int i = 0; i < 3; i++) tick("R4 hold par_en_n");
        load_n = 1'b0; din = ONES;
        tick("R1 load all ones");
        load_n = 1'b1;
        tick("R7 held at ones flag");
        up = 1'b0;
        flag_now("R6 flag follows up");
        up = 1'b1; par_en_n = 1'b0; chain_en_n = 1'b1;
        flag_now("R6 chain enable gates flag");
        for (int i = 0; i < 3; i++) tick("R4 hold chain_en_n");

        // down run across zero (R3 R5)
        chain_en_n = 1'b0; load_n = 1'b0; din = 16'd2;
        tick("R1 load two");
        load_n = 1'b1; up = 1'b0;
        for (int i = 0; i < 300; i++) tick("R3 R5 down wrap");

        // borrow and carry across a byte boundary (R8)
        load_n = 1'b0; din = 16'h0100;
        tick("R1 load 0100");
        load_n = 1'b1;
        tick("R8 borrow across stage");
        up = 1'b1;
        tick("R8 carry across stage");

        // reset mid-count with load pending (R9)
        rst = 1'b1; load_n = 1'b0; din = 16'hBEEF;
        tick("R9 reset beats load");
        rst = 1'b0; load_n = 1'b1;
        tick("R2 after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule